// File: doc/BRIEF.md
# Completed Load Ordering Violation Detector

This block tracks loads that have already received their data, possibly before older stores in program order have resolved their addresses. Each finished load is written into a small buffer with its address, the value it read, and its age tag. When an older store later completes, its address and age are compared against every buffered load. A younger load at the same address has read stale data. The block then reports that load, so the pipeline can squash and re-execute it and every instruction that consumed its value.

An entry leaves the buffer when its load commits as the oldest instruction. A flush removes every entry younger than a given age. Age tags carry a wrap bit in their most significant position. Two tags are ordered by comparing their low bits, and that comparison is inverted when the wrap bits differ. When the buffer is full the insert port deasserts its ready, and load completion must stall. The squash itself and any dependence prediction happen outside this block.

Top module: `ld_order_guard`

## Requirements
- R1: After reset the buffer is empty, `ld_ins_ready` is 1 and `viol_valid` is 0.
- R2: A store check whose address equals a buffered load's address, where that load is younger than the store, produces `viol_valid`=1 with that load's age, address and data.
- R3: A buffered load that is older than the checking store, or that has the same age tag, never causes a violation.
- R4: A buffered load at a different address never causes a violation. The reported `viol_addr` always equals the checking store's address.
- R5: When several younger loads match one store, the violation names the oldest of them.
- R6: A load offered on the insert port in the same cycle as a store check takes part in that check.
- R7: A commit with a given age releases the buffered entry with that age. A later store check no longer finds it, and the freed slot makes `ld_ins_ready` 1 again.
- R8: `ld_ins_ready` is 0 exactly when all slots hold loads. An insert offered while it is 0 is not stored.
- R9: A flush removes every entry strictly younger than `flush_age` and keeps the others. A load inserted in the flush cycle that is younger than `flush_age` is discarded.
- R10: Ages compare modulo 2^AGE_W. A tag L is younger than a tag S when (L-S) mod 2^AGE_W lies in 1 .. 2^(AGE_W-1)-1, including across the wrap point.
- R11: The violation outputs are registered. They appear in the cycle after the store check and drop to `viol_valid`=0 in the next cycle that has no matching check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_ins_valid | input | 1 | A finished load offers an entry |
| ld_ins_ready | output | 1 | A free slot exists |
| ld_ins_addr | input | ADDR_W | Address of the finished load |
| ld_ins_data | input | DATA_W | Value the load read |
| ld_ins_age | input | AGE_W | Age tag of the load, wrap bit on top |
| ld_cmt_valid | input | 1 | The oldest load commits |
| ld_cmt_age | input | AGE_W | Age tag of the committing load |
| st_chk_valid | input | 1 | A store completes and searches the buffer |
| st_chk_addr | input | ADDR_W | Store address |
| st_chk_age | input | AGE_W | Store age tag |
| flush_valid | input | 1 | Discard entries younger than `flush_age` |
| flush_age | input | AGE_W | Flush boundary age |
| viol_valid | output | 1 | An ordering violation was found |
| viol_age | output | AGE_W | Age of the oldest offending load |
| viol_addr | output | ADDR_W | Address of the offending load |
| viol_data | output | DATA_W | Stale value the offending load read |

## Verification
The assertions check several properties on every cycle. Each reported violation follows a store check and names a load younger than that store, at that store's address. At most one candidate and one free slot are ever picked. After a flush, no entry younger than the flush boundary survives. Other behaviours need the bench's scenarios. These include choosing the oldest among several matches, releasing entries on commit, ignoring inserts when the buffer is full, and making a same-cycle insert visible to the check. The bench also sweeps store ages across the wrap point against two load ages. It computes the expected order with modular arithmetic.

// File: rtl/ld_order_pkg.sv
// Shared helpers for the load ordering guard.
// Assumes age tags are at most 32 bits wide, with the wrap bit in the top position.
package ld_order_pkg;

    // True when tag a is older than tag b, for tags w bits wide.
    function automatic logic age_is_older(input logic [31:0] a, input logic [31:0] b,
                                          input int unsigned w);
        logic [31:0] low_mask;
        low_mask = (32'd1 << (w - 1)) - 32'd1;
        if (a[w-1] == b[w-1])
            return (a & low_mask) < (b & low_mask);
        else
            return (a & low_mask) > (b & low_mask);
    endfunction

endpackage

// File: rtl/lob_slot_pick.sv
// Picks the lowest-numbered free slot of the finished-load buffer.
// Assumes valid[i]=1 marks an occupied slot. The grant is one-hot or zero.
module lob_slot_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] valid,
    output logic [N-1:0] grant,
    output logic         found
);
    // Priority scan from slot 0 upward.
    always_comb begin
        grant = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!valid[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lob_cam.sv
// Compares a store against every candidate load: same address and younger age.
// Assumes all live ages lie within half of the tag space.
module lob_cam #(
    parameter int M      = 9,
    parameter int ADDR_W = 16,
    parameter int AGE_W  = 5
) (
    input  logic [M-1:0]             cand_vld,
    input  logic [M-1:0][ADDR_W-1:0] cand_addr,
    input  logic [M-1:0][AGE_W-1:0]  cand_age,
    input  logic [ADDR_W-1:0]        st_addr,
    input  logic [AGE_W-1:0]         st_age,
    output logic [M-1:0]             hit
);
    function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
        return ld_order_pkg::age_is_older(32'(a), 32'(b), AGE_W);
    endfunction

    // One comparator per candidate.
    for (genvar g = 0; g < M; g++) begin : g_cmp
        assign hit[g] = cand_vld[g] && (cand_addr[g] == st_addr) && older(st_age, cand_age[g]);
    end
endmodule

// File: rtl/lob_oldest_sel.sv
// Among the hit candidates, selects the one with the oldest age tag.
// Assumes the hit ages are distinct and within half of the tag space.
module lob_oldest_sel #(
    parameter int M     = 9,
    parameter int AGE_W = 5
) (
    input  logic [M-1:0]            hit,
    input  logic [M-1:0][AGE_W-1:0] age,
    output logic [M-1:0]            sel,
    output logic                    any
);
    function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
        return ld_order_pkg::age_is_older(32'(a), 32'(b), AGE_W);
    endfunction

    // Linear scan that keeps the oldest hit seen so far.
    always_comb begin
        logic [AGE_W-1:0] best_age;
        sel      = '0;
        any      = 1'b0;
        best_age = '0;
        for (int i = 0; i < M; i++) begin
            if (hit[i] && (!any || older(age[i], best_age))) begin
                sel      = '0;
                sel[i]   = 1'b1;
                best_age = age[i];
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ld_order_guard.sv
// Finished-load buffer with store-driven ordering violation detection.
// Holds N completed loads. Each store check compares against the buffered loads
// and against the load offered in the same cycle, and the oldest younger match
// is reported one cycle later. Assumes ages are unique among live loads and
// span less than half of the tag space.
module ld_order_guard #(
    parameter int N      = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int AGE_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_ins_valid,
    output logic              ld_ins_ready,
    input  logic [ADDR_W-1:0] ld_ins_addr,
    input  logic [DATA_W-1:0] ld_ins_data,
    input  logic [AGE_W-1:0]  ld_ins_age,
    input  logic              ld_cmt_valid,
    input  logic [AGE_W-1:0]  ld_cmt_age,
    input  logic              st_chk_valid,
    input  logic [ADDR_W-1:0] st_chk_addr,
    input  logic [AGE_W-1:0]  st_chk_age,
    input  logic              flush_valid,
    input  logic [AGE_W-1:0]  flush_age,
    output logic              viol_valid,
    output logic [AGE_W-1:0]  viol_age,
    output logic [ADDR_W-1:0] viol_addr,
    output logic [DATA_W-1:0] viol_data
);
    localparam int M = N + 1;  // buffered entries plus the same-cycle insert

    function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
        return ld_order_pkg::age_is_older(32'(a), 32'(b), AGE_W);
    endfunction

    logic [N-1:0]             ent_vld;
    logic [N-1:0][ADDR_W-1:0] ent_addr;
    logic [N-1:0][DATA_W-1:0] ent_data;
    logic [N-1:0][AGE_W-1:0]  ent_age;

    logic [N-1:0]             slot_gnt;
    logic                     slot_free;
    logic                     ins_bypass;
    logic                     ins_take;
    logic [N-1:0]             ent_drop;

    logic [M-1:0]             cand_vld;
    logic [M-1:0][ADDR_W-1:0] cand_addr;
    logic [M-1:0][DATA_W-1:0] cand_data;
    logic [M-1:0][AGE_W-1:0]  cand_age;
    logic [M-1:0]             cand_hit;
    logic [M-1:0]             cand_sel;
    logic                     any_hit;

    logic [AGE_W-1:0]         pick_age;
    logic [ADDR_W-1:0]        pick_addr;
    logic [DATA_W-1:0]        pick_data;

    lob_slot_pick #(.N(N)) u_pick (
        .valid (ent_vld),
        .grant (slot_gnt),
        .found (slot_free)
    );

    assign ld_ins_ready = slot_free;
    assign ins_bypass   = ld_ins_valid && slot_free;
    assign ins_take     = ins_bypass && !(flush_valid && older(flush_age, ld_ins_age));

    // Entries released by commit or discarded by flush this cycle.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            ent_drop[i] = ent_vld[i] &&
                          ((ld_cmt_valid && (ent_age[i] == ld_cmt_age)) ||
                           (flush_valid && older(flush_age, ent_age[i])));
        end
    end

    // Candidate list: stored entries followed by the incoming load.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            cand_vld[i]  = ent_vld[i];
            cand_addr[i] = ent_addr[i];
            cand_data[i] = ent_data[i];
            cand_age[i]  = ent_age[i];
        end
        cand_vld[N]  = ins_bypass;
        cand_addr[N] = ld_ins_addr;
        cand_data[N] = ld_ins_data;
        cand_age[N]  = ld_ins_age;
    end

    lob_cam #(.M(M), .ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_cam (
        .cand_vld  (cand_vld),
        .cand_addr (cand_addr),
        .cand_age  (cand_age),
        .st_addr   (st_chk_addr),
        .st_age    (st_chk_age),
        .hit       (cand_hit)
    );

    lob_oldest_sel #(.M(M), .AGE_W(AGE_W)) u_sel (
        .hit (cand_hit),
        .age (cand_age),
        .sel (cand_sel),
        .any (any_hit)
    );

    // One-hot AND-OR mux of the selected candidate's fields.
    always_comb begin
        pick_age  = '0;
        pick_addr = '0;
        pick_data = '0;
        for (int i = 0; i < M; i++) begin
            pick_age  = pick_age  | ({AGE_W{cand_sel[i]}}  & cand_age[i]);
            pick_addr = pick_addr | ({ADDR_W{cand_sel[i]}} & cand_addr[i]);
            pick_data = pick_data | ({DATA_W{cand_sel[i]}} & cand_data[i]);
        end
    end

    // Buffer state update: release, flush and insert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (ent_drop[i])
                    ent_vld[i] <= 1'b0;
                if (ins_take && slot_gnt[i])
                    ent_vld[i] <= 1'b1;
            end
        end
    end

    // Payload capture into the granted slot.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (ins_take && slot_gnt[i]) begin
                ent_addr[i] <= ld_ins_addr;
                ent_data[i] <= ld_ins_data;
                ent_age[i]  <= ld_ins_age;
            end
        end
    end

    // Registered violation report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_valid <= 1'b0;
            viol_age   <= '0;
            viol_addr  <= '0;
            viol_data  <= '0;
        end else begin
            viol_valid <= st_chk_valid && any_hit;
            viol_age   <= pick_age;
            viol_addr  <= pick_addr;
            viol_data  <= pick_data;
        end
    end

    // R2: a violation is only raised after a store check.
    a_r2_viol_after_store: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> $past(st_chk_valid));

    // R3: the reported load is younger than the store that found it.
    a_r3_viol_is_younger: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> older($past(st_chk_age), viol_age));

    // R4: the reported address is the store's address.
    a_r4_viol_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> (viol_addr == $past(st_chk_addr)));

    // R5: the selector picks at most one candidate.
    a_r5_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cand_sel));

    // R8: at most one slot is granted, and only a free one.
    a_r8_one_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_gnt) && ((slot_gnt & ent_vld) == '0));

    // R9: no entry younger than the flush boundary survives a flush.
    for (genvar g = 0; g < N; g++) begin : g_flush_chk
        a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(flush_valid) && ent_vld[g]) |-> !older($past(flush_age), ent_age[g]));
    end
endmodule

// File: tb/ld_order_guard_tb_top.sv
// Self-checking bench with a small configuration and a modular-arithmetic model.
module ld_order_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N      = 4;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int AGE_W  = 4;
    localparam int AMASK  = (1 << AGE_W) - 1;
    localparam int HALF   = 1 << (AGE_W - 1);

    logic clk = 1'b0;
    logic rst_n;
    logic ld_ins_valid, ld_ins_ready, ld_cmt_valid, st_chk_valid, flush_valid, viol_valid;
    logic [ADDR_W-1:0] ld_ins_addr, st_chk_addr, viol_addr;
    logic [DATA_W-1:0] ld_ins_data, viol_data;
    logic [AGE_W-1:0]  ld_ins_age, ld_cmt_age, st_chk_age, flush_age, viol_age;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int m_vld[N];
    int m_addr[N];
    int m_data[N];
    int m_age[N];

    always #(CLK_PERIOD/2) clk = ~clk;

    ld_order_guard #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AGE_W(AGE_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ld_ins_valid(ld_ins_valid), .ld_ins_ready(ld_ins_ready),
        .ld_ins_addr(ld_ins_addr), .ld_ins_data(ld_ins_data), .ld_ins_age(ld_ins_age),
        .ld_cmt_valid(ld_cmt_valid), .ld_cmt_age(ld_cmt_age),
        .st_chk_valid(st_chk_valid), .st_chk_addr(st_chk_addr), .st_chk_age(st_chk_age),
        .flush_valid(flush_valid), .flush_age(flush_age),
        .viol_valid(viol_valid), .viol_age(viol_age), .viol_addr(viol_addr), .viol_data(viol_data)
    );

    function automatic bit younger(int l, int s);
        int d;
        d = (l - s) & AMASK;
        return (d >= 1) && (d < HALF);
    endfunction

    function automatic int model_count();
        int c = 0;
        for (int i = 0; i < N; i++) c += m_vld[i];
        return c;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ld_ins_valid = 0; ld_cmt_valid = 0; st_chk_valid = 0; flush_valid = 0;
        ld_ins_addr = 0; ld_ins_data = 0; ld_ins_age = 0; ld_cmt_age = 0;
        st_chk_addr = 0; st_chk_age = 0; flush_age = 0;
        for (int i = 0; i < N; i++) m_vld[i] = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle: drive at the falling edge, check ready now and the violation after the next rising edge.
    task automatic step(string req, bit iv, int ia, int id, int iage, bit cv, int cage,
                        bit sv, int sa, int sage, bit fv, int fage);
        bit exp_rdy, exp_v;
        int best_d, exp_age, exp_addr, exp_data, d;
        ld_ins_valid = iv; ld_ins_addr = ADDR_W'(ia); ld_ins_data = DATA_W'(id); ld_ins_age = AGE_W'(iage);
        ld_cmt_valid = cv; ld_cmt_age = AGE_W'(cage);
        st_chk_valid = sv; st_chk_addr = ADDR_W'(sa); st_chk_age = AGE_W'(sage);
        flush_valid = fv; flush_age = AGE_W'(fage);
        #1;
        exp_rdy = (model_count() < N);
        check("R8", "ld_ins_ready", int'(ld_ins_ready), int'(exp_rdy));
        exp_v = 0; best_d = 1 << 30; exp_age = 0; exp_addr = 0; exp_data = 0;
        if (sv) begin
            for (int i = 0; i <= N; i++) begin
                bit on; int a, ag, dt;
                if (i < N) begin on = m_vld[i] != 0; a = m_addr[i]; ag = m_age[i]; dt = m_data[i]; end
                else begin on = iv && exp_rdy; a = ia; ag = iage; dt = id; end
                if (on && a == sa && younger(ag, sage)) begin
                    d = (ag - sage) & AMASK;
                    if (d < best_d) begin
                        best_d = d; exp_v = 1; exp_age = ag; exp_addr = a; exp_data = dt;
                    end
                end
            end
        end
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (m_vld[i] != 0 && ((cv && m_age[i] == cage) || (fv && younger(m_age[i], fage))))
                m_vld[i] = 0;
        end
        if (iv && exp_rdy && !(fv && younger(iage, fage))) begin
            for (int i = 0; i < N; i++) begin
                if (m_vld[i] == 0) begin
                    m_vld[i] = 1; m_addr[i] = ia; m_data[i] = id; m_age[i] = iage;
                    break;
                end
            end
        end
        @(negedge clk);
        check(req, "viol_valid", int'(viol_valid), int'(exp_v));
        if (exp_v) begin
            check(req, "viol_age", int'(viol_age), exp_age);
            check(req, "viol_addr", int'(viol_addr), exp_addr);
            check(req, "viol_data", int'(viol_data), exp_data);
        end
        ld_ins_valid = 0; ld_cmt_valid = 0; st_chk_valid = 0; flush_valid = 0;
    endtask

    task automatic ins(string req, int a, int d, int ag);
        step(req, 1, a, d, ag, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic st(string req, int a, int ag);
        step(req, 0, 0, 0, 0, 0, 0, 1, a, ag, 0, 0);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1", "ld_ins_ready", int'(ld_ins_ready), 1);
        check("R1", "viol_valid", int'(viol_valid), 0);

        // R2: basic younger-load hit
        ins("R2", 'h10, 'h33, 3);
        st("R2", 'h10, 1);
        // R11: report drops in the next idle cycle
        step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R11", "viol_valid idle", int'(viol_valid), 0);

        // R3: older and equal-age loads are ignored
        st("R3", 'h10, 5);
        st("R3", 'h10, 3);
        // R4: different address
        st("R4", 'h11, 1);

        // R5: oldest among several matches
        ins("R5", 'h20, 'h66, 6);
        ins("R5", 'h20, 'h44, 4);
        st("R5", 'h20, 2);

        // R6: same-cycle insert is visible to the check (buffer becomes full)
        step("R6", 1, 'h30, 'h77, 7, 0, 0, 1, 'h30, 5, 0, 0);

        // R8: full buffer ignores an insert
        check("R8", "ready when full", int'(ld_ins_ready), 0);
        ins("R8", 'h40, 'h88, 8);
        st("R8", 'h40, 2);

        // R7: commit releases the entry and frees a slot
        step("R7", 0, 0, 0, 0, 1, 3, 0, 0, 0, 0, 0);
        check("R7", "ready after commit", int'(ld_ins_ready), 1);
        st("R7", 'h10, 1);

        // R9: flush removes younger entries and a younger same-cycle insert
        step("R9", 1, 'h50, 'h55, 6, 0, 0, 0, 0, 0, 1, 5);
        st("R9", 'h20, 2);
        st("R9", 'h30, 5);
        st("R9", 'h50, 5);
        st("R9", 'h20, 3);

        // R10: sweep store ages across the wrap point for two load ages
        foreach (m_vld[k]) m_vld[k] = m_vld[k];
        for (int li = 0; li < 2; li++) begin
            int lage;
            lage = (li == 0) ? 8 : 1;
            do_reset();
            ins("R10", 'h60, 'h90 + lage, lage);
            for (int s = 0; s <= AMASK; s++) begin
                if (((lage - s) & AMASK) != HALF)
                    st("R10", 'h60, s);
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule